// File: doc/BRIEF.md
# Serial Register Readback Serialiser

This block is the read path of a four-channel serial converter interface. Once the upstream header decoder has recognised a read instruction, it pulses `hdr_valid` together with the decoded fields. The block then shifts out the 10-bit word of one channel, or the words of all four channels back to back, on a single data-out line with a separate output enable. The host can therefore confirm what was latched into the input registers before it commits an update.

For each transaction the host picks the bit order (most-significant first or least-significant first). It also picks the serial-clock edge on which the output changes. One idle bit time follows the header in both cases. With the falling-edge choice the first bit appears on the second falling edge after the header's last sampling edge. With the rising-edge choice it appears on the second rising edge, half a period later. When the stream is exhausted the last bit stays on the line. Deasserting chip select releases the line in the same cycle.

The block runs on a fast system clock. The serial clock is a synchronous input whose edges are detected by comparing it with its value one cycle earlier.

Top module: `serial_readback`

## Requirements
- R1: After reset `sdo_oe` is 0 and `sdo` is 0. `sdo` reads 0 whenever `sdo_oe` is 0.
- R2: The header fields are captured in the cycle `hdr_valid` is 1 while `cs_n` is 0. `hdr_addr` values 0,1,2,3 select channel words `chan_words[9:0]`, `[19:10]`, `[29:20]` and `[39:30]`.
- R3: With `hdr_edge`=0 the first bit is loaded on the second falling `sck` edge detected after the `hdr_valid` cycle. Each later bit is loaded on a later falling edge, and rising edges leave `sdo` unchanged.
- R4: With `hdr_edge`=1 the first bit is loaded on the second rising `sck` edge detected after the `hdr_valid` cycle. Each later bit is loaded on a later rising edge, and falling edges leave `sdo` unchanged.
- R5: With `hdr_msb`=1 a word is sent as bit 9 down to bit 0. With `hdr_msb`=0 it is sent as bit 0 up to bit 9.
- R6: With `hdr_global`=0 exactly 10 bits of the addressed channel are sent.
- R7: With `hdr_global`=1, 40 bits are sent: channel 0, then 1, 2 and 3, and `hdr_addr` is ignored.
- R8: After the last bit, `sdo` holds that bit and `sdo_oe` stays 1 until `cs_n` rises, whatever the edges on `sck`.
- R9: `cs_n`=1 drops `sdo_oe` in the same cycle and abandons the transaction.
- R10: A `hdr_valid` pulse while `cs_n` is 1 starts nothing. `sdo_oe` stays 0 through the edges that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| hdr_valid | input | 1 | One-cycle pulse: decoded read header present |
| hdr_global | input | 1 | 1 = stream all channels |
| hdr_edge | input | 1 | 1 = change on rising sck, 0 = falling |
| hdr_msb | input | 1 | 1 = most-significant bit first |
| hdr_addr | input | 2 | Channel select for single reads |
| chan_words | input | 40 | Four stored 10-bit words, channel 0 in the low bits |
| sdo | output | 1 | Serial data out (0 when disabled) |
| sdo_oe | output | 1 | Output enable for the data-out pad |

## Verification
Two events can fall in the same cycle. One is a launch-edge shift of the next bit. The other is the rise of `cs_n`, or a new `hdr_valid`, which must win over that shift. The bench raises `cs_n` in the middle of a stream, right where a launch edge is due. It checks that the enable drops within that same cycle and that the next header starts again from a fresh idle bit. A behavioural queue model, compared every clock, judges which event took effect.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    RB_IDLE = 2'd0,
    RB_WAIT = 2'd1,
    RB_SEND = 2'd2
  } rb_state_e;

  // Position in the stream -> bit index in the word, per order choice
  function automatic int unsigned pick_index(int unsigned pos, bit msb_first,
                                             int unsigned width);
    return msb_first ? (width - 1 - pos) : pos;
  endfunction

endpackage

// File: rtl/rb_edge_det.sv
module rb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
  import rb_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 4,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             hdr_valid,
  input  logic             hdr_global,
  input  logic             hdr_edge,
  input  logic             hdr_msb,
  input  logic [CH_W-1:0]  hdr_addr,
  input  logic             sck_rise,
  input  logic             sck_fall,
  output logic             sending,
  output logic             shift_en,
  output logic             edge_q,
  output logic             msb_q,
  output logic [CH_W-1:0]  nxt_ch,
  output logic [BIT_W-1:0] nxt_bit
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);

  rb_state_e        state_q;
  logic             skip_q, glob_q;
  logic [CH_W-1:0]  addr_q, ch_q;
  logic [BIT_W-1:0] bit_q;

  logic launch_edge, first_load, step, at_last;

  assign launch_edge = edge_q ? sck_rise : sck_fall;
  assign at_last     = (bit_q == LAST_BIT) && (!glob_q || (ch_q == LAST_CH));
  assign first_load  = (state_q == RB_WAIT) && skip_q && launch_edge;
  assign step        = (state_q == RB_SEND) && launch_edge && !at_last;
  assign shift_en    = !cs_n && !hdr_valid && (first_load || step);
  assign sending     = (state_q == RB_SEND);

  always_comb begin
    if (first_load) begin
      nxt_bit = '0;
      nxt_ch  = glob_q ? '0 : addr_q;
    end else if (bit_q == LAST_BIT) begin
      nxt_bit = '0;
      nxt_ch  = ch_q + 1'b1;
    end else begin
      nxt_bit = bit_q + 1'b1;
      nxt_ch  = ch_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RB_IDLE;
      skip_q  <= 1'b0;
      glob_q  <= 1'b0;
      edge_q  <= 1'b0;
      msb_q   <= 1'b0;
      addr_q  <= '0;
      ch_q    <= '0;
      bit_q   <= '0;
    end else if (cs_n) begin
      state_q <= RB_IDLE;
      skip_q  <= 1'b0;
    end else if (hdr_valid) begin
      state_q <= RB_WAIT;
      skip_q  <= 1'b0;
      glob_q  <= hdr_global;
      edge_q  <= hdr_edge;
      msb_q   <= hdr_msb;
      addr_q  <= hdr_addr;
    end else begin
      if (state_q == RB_WAIT && launch_edge) begin
        if (skip_q) state_q <= RB_SEND;
        else        skip_q  <= 1'b1;
      end
      if (shift_en) begin
        bit_q <= nxt_bit;
        ch_q  <= nxt_ch;
      end
    end
  end
endmodule

// File: rtl/rb_bit_select.sv
module rb_bit_select
  import rb_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 4,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*WORD_W-1:0] words,
  input  logic [CH_W-1:0]          ch,
  input  logic [BIT_W-1:0]         bit_pos,
  input  logic                     msb_first,
  output logic                     bit_out
);
  logic [WORD_W-1:0] word_arr [NUM_CH];
  logic [BIT_W-1:0]  idx;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign word_arr[g] = words[g*WORD_W +: WORD_W];
  end

  assign idx     = BIT_W'(pick_index(int'(bit_pos), msb_first, WORD_W));
  assign bit_out = word_arr[ch][idx];
endmodule

// File: rtl/serial_readback.sv
module serial_readback #(
  parameter int WORD_W = 10,
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck,
  input  logic                       cs_n,
  input  logic                       hdr_valid,
  input  logic                       hdr_global,
  input  logic                       hdr_edge,
  input  logic                       hdr_msb,
  input  logic [$clog2(NUM_CH)-1:0]  hdr_addr,
  input  logic [NUM_CH*WORD_W-1:0]   chan_words,
  output logic                       sdo,
  output logic                       sdo_oe
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int CH_W  = $clog2(NUM_CH);

  logic             sck_rise, sck_fall;
  logic             sending, shift_en, edge_q, msb_q, sel_bit, sdo_q;
  logic [CH_W-1:0]  nxt_ch;
  logic [BIT_W-1:0] nxt_bit;

  rb_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  rb_sequencer #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .hdr_valid(hdr_valid), .hdr_global(hdr_global), .hdr_edge(hdr_edge),
    .hdr_msb(hdr_msb), .hdr_addr(hdr_addr),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sending(sending), .shift_en(shift_en), .edge_q(edge_q), .msb_q(msb_q),
    .nxt_ch(nxt_ch), .nxt_bit(nxt_bit)
  );

  rb_bit_select #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_sel (
    .words(chan_words), .ch(nxt_ch), .bit_pos(nxt_bit),
    .msb_first(msb_q), .bit_out(sel_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (shift_en) sdo_q <= sel_bit;
  end

  assign sdo_oe = sending & ~cs_n;
  assign sdo    = sdo_oe & sdo_q;
endmodule

// File: rtl/rb_checker.sv
module rb_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck_rise,
  input logic sck_fall,
  input logic edge_q,
  input logic shift_en,
  input logic sdo,
  input logic sdo_oe
);
  // R1
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R9
  release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  // R3 R4
  shift_on_chosen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (edge_q ? sck_rise : sck_fall));

  // R8
  hold_between_shifts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(shift_en)) |-> $stable(sdo));

  // R10
  enable_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(!cs_n));
endmodule

bind serial_readback rb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .edge_q(edge_q), .shift_en(shift_en),
  .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/serial_readback_tb.sv
module serial_readback_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        hdr_valid = 1'b0;
  logic        hdr_global = 1'b0, hdr_edge = 1'b0, hdr_msb = 1'b0;
  logic [1:0]  hdr_addr = 2'd0;
  logic [39:0] chan_words = '0;
  logic        sdo, sdo_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  serial_readback u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .hdr_valid(hdr_valid), .hdr_global(hdr_global), .hdr_edge(hdr_edge),
    .hdr_msb(hdr_msb), .hdr_addr(hdr_addr), .chan_words(chan_words),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 idle, 1 waiting idle bit, 2 streaming
  int m_state = 0;
  bit m_skip = 0, m_edge = 0, m_prev = 0, m_sdo = 0;
  bit m_q[$];

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_state = 0; m_prev = 0; m_q.delete();
    end else begin
      bit rise, fall, ev;
      rise = sck && !m_prev;
      fall = !sck && m_prev;
      ev = m_edge ? rise : fall;
      if (cs_n) begin
        m_state = 0;
      end else if (hdr_valid) begin
        m_state = 1; m_skip = 0; m_edge = hdr_edge;
        m_q.delete();
        for (int c = 0; c < 4; c++) begin
          if (hdr_global || c == int'(hdr_addr)) begin
            for (int i = 0; i < 10; i++)
              m_q.push_back(chan_words[c*10 + (hdr_msb ? 9 - i : i)]);
          end
        end
      end else if (m_state == 1 && ev) begin
        if (m_skip) begin m_state = 2; m_sdo = m_q.pop_front(); end
        else m_skip = 1;
      end else if (m_state == 2 && ev && m_q.size() > 0) begin
        m_sdo = m_q.pop_front();
      end
      m_prev = sck;
    end
    #1;
    if (!done) begin
      bit e_oe;
      e_oe = (m_state == 2) && !cs_n;
      chk(sdo_oe == e_oe, cur_req, "sdo_oe", int'(sdo_oe), int'(e_oe));
      chk(sdo == (e_oe & m_sdo), cur_req, "sdo", int'(sdo), int'(e_oe & m_sdo));
    end
  end

  task automatic sck_periods(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic start_read(input bit g, input bit e, input bit m, input logic [1:0] a,
                            input bit sel);
    @(negedge clk); cs_n = ~sel;
    repeat (3) @(negedge clk);
    sck = 1'b1; hdr_valid = 1'b1;
    hdr_global = g; hdr_edge = e; hdr_msb = m; hdr_addr = a;
    @(negedge clk); hdr_valid = 1'b0;
    repeat (3) @(negedge clk); sck = 1'b0;
  endtask

  task automatic end_read();
    @(negedge clk); cs_n = 1'b1;
    #1 chk(sdo_oe == 1'b0, "R9", "oe after deselect", int'(sdo_oe), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit held;
    chan_words = {10'h3C8, 10'h0F3, 10'h155, 10'h201};
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1", "reset outputs", int'({sdo_oe, sdo}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_req = "R2 R3 R5 R6";   // channel 1, falling, LSB first
    start_read(1'b0, 1'b0, 1'b0, 2'd1, 1'b1); sck_periods(13); end_read();

    cur_req = "R2 R4 R5 R6";   // channel 3, rising, MSB first
    start_read(1'b0, 1'b1, 1'b1, 2'd3, 1'b1); sck_periods(13); end_read();

    cur_req = "R2 R3 R5 R6";   // channel 0, falling, MSB first
    start_read(1'b0, 1'b0, 1'b1, 2'd0, 1'b1); sck_periods(12); end_read();

    cur_req = "R7 R3 R5 R8";   // global, falling, MSB first, addr 10
    chan_words = {10'h2AA, 10'h3FF, 10'h001, 10'h18C};
    start_read(1'b1, 1'b0, 1'b1, 2'd2, 1'b1); sck_periods(45);
    held = sdo;
    sck_periods(3);
    chk(sdo_oe == 1'b1 && sdo == held, "R8", "hold after last bit",
        int'({sdo_oe, sdo}), int'({1'b1, held}));
    end_read();

    cur_req = "R7 R4 R5";      // global, rising, LSB first, addr ignored
    start_read(1'b1, 1'b1, 1'b0, 2'd3, 1'b1); sck_periods(44); end_read();

    cur_req = "R9";            // deselect mid-stream on a launch edge
    start_read(1'b1, 1'b0, 1'b0, 2'd2, 1'b1); sck_periods(6);
    repeat (4) @(negedge clk); sck = 1'b1;
    repeat (4) @(negedge clk); sck = 1'b0; cs_n = 1'b1;
    #1 chk(sdo_oe == 1'b0, "R9", "same-cycle release", int'(sdo_oe), 0);
    repeat (6) @(negedge clk);
    cur_req = "R9 R6";         // fresh read after abandoned one
    start_read(1'b0, 1'b0, 1'b0, 2'd2, 1'b1); sck_periods(12); end_read();

    cur_req = "R10";           // header while deselected
    start_read(1'b0, 1'b0, 1'b1, 2'd0, 1'b0); sck_periods(5);
    chk(sdo_oe == 1'b0, "R10", "ignored header", int'(sdo_oe), 0);
    repeat (4) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule